// File: doc/BRIEF.md
# Signed Multiplier with Overflow Flag

This block multiplies two signed integers for a 64-bit integer datapath. It runs over several cycles. A one-cycle request pulse carries two 64-bit operands and a mode bit. In word mode only the low halves of the operands count. They are treated as 32-bit signed numbers, and their full 64-bit signed product is returned. In doubleword mode both complete operands are multiplied as signed numbers. Only the low 64 bits of the 128-bit product are returned.

An overflow flag comes back with the product. It is set when the returned value, read as a signed number of the kept width (32 bits in word mode, 64 bits in doubleword mode), differs from the true product. The test looks at a window of the product's high bits. That window runs from the top of the product down to the sign bit of the kept part, and the flag is clear only when every bit in it is equal.

The engine is an iterative radix-4 Booth recoder that retires two multiplier bits per cycle. Word mode stops after half as many steps as doubleword mode. The block ignores requests that arrive while it is working. It holds its last answer until the next operation completes.

Top module: `smul_ovf`

## Requirements
- R1: With `dword_i`=0, `result_o` equals the signed product of `opa_i[31:0]` and `opb_i[31:0]`, each read as a 32-bit two's-complement number, given as a 64-bit two's-complement value.
- R2: With `dword_i`=0, `ovf_o` is 1 exactly when that product lies outside the range -2^31 to 2^31-1, that is, when product bits 63 down to 31 are not all equal.
- R3: With `dword_i`=1, `result_o` equals bits 63:0 of the 128-bit signed product of `opa_i` and `opb_i`.
- R4: With `dword_i`=1, `ovf_o` is 1 exactly when the 128-bit product lies outside -2^63 to 2^63-1, that is, when product bits 127 down to 63 are not all equal.
- R5: The most negative operand is handled exactly. Squaring it sets `ovf_o` in both modes. Multiplying it by -1 also sets `ovf_o` in both modes. Multiplying it by +1 returns it with `ovf_o`=0.
- R6: A request is accepted on a rising edge with `start_i`=1 while `busy_o`=0. From the next cycle `busy_o` stays 1 until `valid_o` pulses for exactly one cycle with `busy_o`=0. In word mode `valid_o` is seen 17 clock edges after the accepting edge, and in doubleword mode 33 edges after it.
- R7: `start_i` while `busy_o`=1 is ignored. That includes the last busy cycle. The running operation completes with its own operands and mode, and no extra `valid_o` pulse follows.
- R8: `result_o` and `ovf_o` change only in the cycle `valid_o` rises. They keep their values across later idle cycles and through the next operation until it completes.
- R9: In word mode, `opa_i[63:32]` and `opb_i[63:32]` have no effect on `result_o` or `ovf_o`.
- R10: During reset `busy_o`=0, `valid_o`=0, `result_o`=0 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; taken only while idle |
| dword_i | input | 1 | Mode: 0 = 32x32 to 64, 1 = 64x64 keep low 64 |
| opa_i | input | 64 | Multiplicand |
| opb_i | input | 64 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| valid_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Kept product, held until the next completion |
| ovf_o | output | 1 | Kept product differs from the true signed product |

## Verification
Completion and acceptance can land in the same clock. The scoreboard driver sends the next request in the very cycle `valid_o` is high. The monitor must then still read the finished product, and the new request must come back later with its own correct value and latency. A dropped request and the final busy cycle can also coincide. The bench pulses `start_i` with different operands and the opposite mode exactly in that last busy cycle. It passes only if the queued expectation for the original operands matches and no unexpected `valid_o` appears.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    BD_ZERO = 3'd0,
    BD_P1   = 3'd1,
    BD_P2   = 3'd2,
    BD_M1   = 3'd3,
    BD_M2   = 3'd4
  } booth_e;

  // Radix-4 Booth recode of {b[i+1], b[i], b[i-1]}
  function automatic booth_e booth_recode(input logic [2:0] trio);
    case (trio)
      3'b001, 3'b010: return BD_P1;
      3'b011:         return BD_P2;
      3'b100:         return BD_M2;
      3'b101, 3'b110: return BD_M1;
      default:        return BD_ZERO;
    endcase
  endfunction

  // True when every bit of the slice is equal (pure sign run)
  function automatic logic sign_run(input logic [127:0] v, input int unsigned nbits);
    logic all1, all0;
    all1 = 1'b1;
    all0 = 1'b1;
    for (int k = 0; k < 128; k++) begin
      if (k < nbits) begin
        all1 = all1 & v[k];
        all0 = all0 & ~v[k];
      end
    end
    return all1 | all0;
  endfunction

endpackage

// File: rtl/smul_opsel.sv
module smul_opsel #(
  parameter int XLEN = 64,
  parameter int CW   = 6
) (
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] mcand_o,
  output logic [XLEN-1:0] mplier_o,
  output logic [CW-1:0]   steps_o
);
  localparam int H = XLEN / 2;

  always_comb begin
    if (word_i) begin
      mcand_o  = {{(XLEN-H){a_i[H-1]}}, a_i[H-1:0]};
      mplier_o = {{(XLEN-H){b_i[H-1]}}, b_i[H-1:0]};
      steps_o  = CW'(H / 2);
    end else begin
      mcand_o  = a_i;
      mplier_o = b_i;
      steps_o  = CW'(XLEN / 2);
    end
  end

endmodule

// File: rtl/smul_booth_core.sv
module smul_booth_core
  import smul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] mcand_i,
  input  logic [XLEN-1:0] mplier_i,
  input  logic [CW-1:0]   steps_i,
  output logic            running_o,
  output logic            last_o,
  output logic [XLEN+1:0] acc_hi_o,
  output logic [XLEN-1:0] acc_lo_o
);
  localparam int HW = XLEN + 2;
  localparam int FW = 2 * XLEN + 2;

  logic [XLEN-1:0] mcand_q;
  logic [XLEN-1:0] mq_q;
  logic            prev_q;
  logic [CW-1:0]   cnt_q;
  logic [HW-1:0]   hi_q;
  logic [XLEN-1:0] lo_q;

  booth_e          digit;
  logic [HW-1:0]   ax;
  logic [HW-1:0]   pp;
  logic [HW-1:0]   sum;
  logic [FW-1:0]   shifted;

  assign digit = booth_recode({mq_q[1:0], prev_q});
  assign ax    = {{2{mcand_q[XLEN-1]}}, mcand_q};

  always_comb begin
    case (digit)
      BD_P1:   pp = ax;
      BD_P2:   pp = ax << 1;
      BD_M1:   pp = -ax;
      BD_M2:   pp = -(ax << 1);
      default: pp = '0;
    endcase
  end

  assign sum     = hi_q + pp;
  assign shifted = FW'($signed({sum, lo_q}) >>> 2);

  assign running_o = (cnt_q != '0);
  assign last_o    = (cnt_q == CW'(1));
  assign acc_hi_o  = hi_q;
  assign acc_lo_o  = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mq_q    <= '0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mq_q    <= mplier_i;
      prev_q  <= 1'b0;
      cnt_q   <= steps_i;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (running_o) begin
      mq_q    <= mq_q >> 2;
      prev_q  <= mq_q[1];
      cnt_q   <= cnt_q - CW'(1);
      hi_q    <= shifted[FW-1:XLEN];
      lo_q    <= shifted[XLEN-1:0];
    end
  end

  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !running_o);

  a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(XLEN / 2));

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/smul_result_fmt.sv
module smul_result_fmt
  import smul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            check_i,
  input  logic            word_i,
  input  logic [XLEN+1:0] acc_hi_i,
  input  logic [XLEN-1:0] acc_lo_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  localparam int H = XLEN / 2;

  logic [XLEN-1:0] p_word;
  logic [H:0]      word_win;
  logic [XLEN:0]   dw_win;
  logic            word_fits;
  logic            dw_fits;

  // word mode: 2*H-bit product = hi[H-1:0] : lo[XLEN-1:H]
  assign p_word   = {acc_hi_i[H-1:0], acc_lo_i[XLEN-1:H]};
  assign word_win = p_word[XLEN-1:H-1];
  assign dw_win   = {acc_hi_i[XLEN-1:0], acc_lo_i[XLEN-1]};

  assign word_fits = sign_run(128'(word_win), H + 1);
  assign dw_fits   = sign_run(128'(dw_win), XLEN + 1);

  assign res_o = word_i ? p_word : acc_lo_i;
  assign ovf_o = word_i ? ~word_fits : ~dw_fits;

  // a 32x32 product never reaches above bit 63: upper accumulator is sign fill
  a_r1_word_hi_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (check_i && word_i) |-> (acc_hi_i[XLEN+1:H] == {(XLEN+2-H){acc_hi_i[H-1]}}));

  a_r3_dw_hi_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (check_i && !word_i) |-> (acc_hi_i[XLEN+1:XLEN] == {2{acc_hi_i[XLEN-1]}}));

endmodule

// File: rtl/smul_ovf.sv
module smul_ovf
  import smul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dword_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            busy_o,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o
);
  localparam int CW = $clog2(XLEN / 2 + 1);

  seq_state_e      state_q;
  logic            word_q;
  logic            valid_q;
  logic [XLEN-1:0] res_q;
  logic            ovf_q;

  logic            accept;
  logic            start_dropped;
  logic            fin_evt;

  logic [XLEN-1:0] mcand;
  logic [XLEN-1:0] mplier;
  logic [CW-1:0]   steps;
  logic            core_running;
  logic            core_last;
  logic [XLEN+1:0] acc_hi;
  logic [XLEN-1:0] acc_lo;
  logic [XLEN-1:0] fmt_res;
  logic            fmt_ovf;

  assign accept        = start_i && (state_q == SEQ_IDLE);
  assign start_dropped = start_i && (state_q != SEQ_IDLE);
  assign fin_evt       = (state_q == SEQ_FIN);

  smul_opsel #(.XLEN(XLEN), .CW(CW)) u_opsel (
    .word_i   (~dword_i),
    .a_i      (opa_i),
    .b_i      (opb_i),
    .mcand_o  (mcand),
    .mplier_o (mplier),
    .steps_o  (steps)
  );

  smul_booth_core #(.XLEN(XLEN), .CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .steps_i   (steps),
    .running_o (core_running),
    .last_o    (core_last),
    .acc_hi_o  (acc_hi),
    .acc_lo_o  (acc_lo)
  );

  smul_result_fmt #(.XLEN(XLEN)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .check_i  (fin_evt),
    .word_i   (word_q),
    .acc_hi_i (acc_hi),
    .acc_lo_i (acc_lo),
    .res_o    (fmt_res),
    .ovf_o    (fmt_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      word_q  <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (accept) begin
          state_q <= SEQ_RUN;
          word_q  <= ~dword_i;
        end
        SEQ_RUN: if (core_running && core_last) state_q <= SEQ_FIN;
        SEQ_FIN: begin
          res_q   <= fmt_res;
          ovf_q   <= fmt_ovf;
          valid_q <= 1'b1;
          state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != SEQ_IDLE);
  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

  a_r6_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  a_r6_run_has_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN) |-> core_running);

  a_r7_drop_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    start_dropped |=> $stable(word_q));

  a_r7_drop_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_dropped && fin_evt) |=> (valid_o && !busy_o));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> ($stable(result_o) && $stable(ovf_o)));

endmodule

// File: tb/sim_smul_ovf.sv
module sim_smul_ovf;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    int unsigned due;
    string       rtag;
    string       otag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dword_i = 1'b0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        busy_o, valid_o, ovf_o;
  logic [63:0] result_o;

  int unsigned cyc = 0;
  int          total = 0;
  int          bad = 0;
  exp_t        exp_q[$];
  logic        have_last = 1'b0;
  logic [63:0] last_res;
  logic        last_ovf;
  logic        done_flag = 1'b0;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAX64 = 64'h7fff_ffff_ffff_ffff;
  localparam logic [63:0] MIN32 = 64'h0000_0000_8000_0000;
  localparam logic [63:0] MAX32 = 64'h0000_0000_7fff_ffff;

  smul_ovf u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dword_i(dword_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .valid_o(valid_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // independent reference: range test instead of a bit window
  task automatic model(input bit dw, input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] res, output logic ovf);
    if (!dw) begin
      longint p;
      p   = longint'(int'(a[31:0])) * longint'(int'(b[31:0]));
      res = p;
      ovf = (p > 64'sd2147483647) || (p < -64'sd2147483648);
    end else begin
      logic signed [127:0] p;
      p   = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
      res = p[63:0];
      ovf = (p > $signed({65'b0, {63{1'b1}}})) || (p < $signed({{65{1'b1}}, 63'b0}));
    end
  endtask

  // driver: waits for idle, issues a request, optionally intrudes later
  task automatic issue(input bit dw, input logic [63:0] a, input logic [63:0] b,
                       input string rt, input string ot, input int intrude);
    exp_t e;
    int   steps;
    steps = dw ? 32 : 16;
    while (busy_o) @(negedge clk);
    start_i = 1'b1; dword_i = dw; opa_i = a; opb_i = b;
    model(dw, a, b, e.res, e.ovf);
    e.due  = cyc + steps + 2;
    e.rtag = rt;
    e.otag = ot;
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R6", "busy after accept", 64'(busy_o), 64'd1);
    if (intrude > 0) begin
      repeat (intrude - 1) @(negedge clk);
      // R7: foreign request while busy, opposite mode
      start_i = 1'b1; dword_i = ~dw; opa_i = ~a; opb_i = b ^ 64'h5a5a;
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (valid_o) begin
        check(busy_o === 1'b0, "R6", "busy low at valid", 64'(busy_o), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected valid", 64'(valid_o), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(result_o === e.res, e.rtag, "product", result_o, e.res);
          check(ovf_o === e.ovf, e.otag, "overflow", 64'(ovf_o), 64'(e.ovf));
          check(cyc == e.due, "R6", "latency", 64'(cyc), 64'(e.due));
        end
        have_last = 1'b1;
        last_res  = result_o;
        last_ovf  = ovf_o;
      end else if (have_last) begin
        check(result_o === last_res && ovf_o === last_ovf, "R8", "held result",
              result_o, last_res);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] c32[6];
    logic [63:0] c64[6];
    c32 = '{64'd0, 64'd1, 64'hffff_ffff, MIN32, MAX32, 64'h8000_0001};
    c64 = '{64'd0, 64'd1, '1, MIN64, MAX64, 64'h8000_0000_0000_0001};

    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && valid_o === 1'b0, "R10", "ctrl in reset",
          {62'd0, busy_o, valid_o}, 64'd0);
    check(result_o === 64'd0 && ovf_o === 1'b0, "R10", "data in reset", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 min-operand cases, both modes
    issue(1'b0, MIN32, MIN32, "R5", "R5", 0);
    issue(1'b1, MIN64, MIN64, "R5", "R5", 0);
    issue(1'b0, MIN32, 64'hffff_ffff, "R5", "R5", 0);
    issue(1'b1, MIN64, '1, "R5", "R5", 0);
    issue(1'b0, MIN32, 64'd1, "R5", "R5", 0);
    issue(1'b1, MIN64, 64'd1, "R5", "R5", 0);

    // corner grids: R1/R2 and R3/R4
    foreach (c32[i]) foreach (c32[j]) issue(1'b0, c32[i], c32[j], "R1", "R2", 0);
    foreach (c64[i]) foreach (c64[j]) issue(1'b1, c64[i], c64[j], "R3", "R4", 0);

    // R9 word mode with junk in upper halves
    for (int k = 0; k < 12; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      issue(1'b0, a, b, "R9", "R9", 0);
    end

    // R7 intrusions: first busy cycle, mid, and last busy cycle
    issue(1'b0, 64'h1234_5678, 64'hfedc_ba98, "R7", "R7", 1);
    issue(1'b1, MAX64, 64'd3, "R7", "R7", 9);
    issue(1'b0, MAX32, MAX32, "R7", "R7", 17);
    issue(1'b1, 64'hdead_beef_0000_1111, 64'h0000_0003_0000_0001, "R7", "R7", 33);

    // random mixed traffic, back-to-back issue
    for (int k = 0; k < 150; k++) begin
      logic [63:0] a, b;
      bit dw;
      dw = $urandom_range(0, 1);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 3 == 0) b = {{40{b[23]}}, b[23:0]};
      issue(dw, a, b, dw ? "R3" : "R1", dw ? "R4" : "R2", 0);
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule